// File: doc/BRIEF.md
# Bang-Bang Receive Phase Tracking Controller

This block is the digital half of a delay-locked receive clock. A sampler built as a copy of the data input receiver watches the reference and gives one bit per update: the sampling edge is early, or it is late. The controller adds these one-bit votes into an accumulator. The accumulator is the only loop filter: one integrator with no proportional path, so the loop is first order and always stable. The update rate and the accumulator step size set the loop gain. Because the phase detector is a copy of the receiver, the edge the loop settles on already takes the receiver's setup time into account.

The top bits of the accumulator form a phase code. The code picks one of twelve evenly spaced edges taken from a six-stage differential delay line. It also gives an interpolation weight toward the next edge, in eighths. The code wraps around the full circle in both directions, so the tracked edge can slip by any number of turns with no jump. A lock flag rises once the votes have stayed balanced for a long stretch. It drops when a long one-sided run shows the loop is slewing.

Top module: `bb_phase_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the phase code becomes 0 (coarse select 0, `wt_next` 0, `wt_this` 8, `next_sel` 1) and `lock` becomes 0. This shows at the outputs one cycle after the edge.
- R2: On an edge where `upd_vld` is low, the phase code and `lock` keep their values, whatever `pd_early` is.
- R3: On an edge where `upd_vld` is high, the accumulator (FRAC_BITS fractional bits below the phase code) grows by STEP if `pd_early` is 1 and shrinks by STEP if it is 0. The phase code is the accumulator without its fractional bits. With the defaults FRAC_BITS=2 and STEP=2, the code moves by one for every two votes in the same direction.
- R4: The phase code runs from 0 to 95. `coarse_sel` is the code divided by 8 (0..11), and `wt_next` is the code modulo 8. A carry out of the weight field advances `coarse_sel` by one.
- R5: The accumulator wraps modulo 96·2^FRAC_BITS. Stepping up past code 95 continues at code 0. Stepping down below 0 continues at code 95 (coarse 11, weight 7).
- R6: `wt_this` equals 8 − `wt_next`, so the two interpolator weights always add up to 8.
- R7: `next_sel` is (`coarse_sel` + 1) modulo 12, so it is 0 when `coarse_sel` is 11.
- R8: The valid updates are grouped into windows of 8. A window is balanced when its early and late counts differ by at most 2, which means 3, 4 or 5 early votes. `lock` rises at the edge that closes the 16th balanced window in a row.
- R9: A window that is not balanced restarts the count of balanced windows, so 16 more balanced windows are needed for lock.
- R10: When 8 valid votes in a row have the same direction, `lock` is cleared at the edge of the 8th vote, and the count of balanced windows restarts. A run of 7 leaves `lock` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_vld | input | 1 | Marks a cycle that carries a phase vote |
| pd_early | input | 1 | Vote from the replica sampler: 1 = edge early (move later), 0 = edge late (move earlier) |
| coarse_sel | output | 4 | Selected delay-line edge, 0..11 |
| next_sel | output | 4 | Adjacent edge that the interpolator blends toward |
| wt_this | output | 4 | Drive weight on `coarse_sel`, 1..8 |
| wt_next | output | 4 | Drive weight on `next_sel`, 0..7 |
| lock | output | 1 | Loop judged settled |

## Verification
A wrong accumulator value shows on the code outputs one edge after the vote that caused it. Because the fractional bits hide half the steps, a fault in them shows only one vote later, when the code moves at the wrong vote or does not move. Wrap faults show only at the ends of the circle, so the vector walk crosses code 0 in both directions and crosses a weight carry. A fault in the window or run counters shows only at the lock output, and sometimes only after more than a hundred votes. The lock tests therefore sample `lock` one vote before and one vote after each expected change, including after a failed window and after a 5-to-3 split.

// File: rtl/bb_phase_pkg.sv
`timescale 1ns/1ps
package bb_phase_pkg;
    localparam int PH_COARSE    = 12;
    localparam int PH_FINE_W    = 3;
    localparam int PH_FINE      = 1 << PH_FINE_W;
    localparam int PH_CODE_SPAN = PH_COARSE * PH_FINE;
    localparam int PH_CODE_W    = $clog2(PH_CODE_SPAN);
    localparam int PH_SEL_W     = $clog2(PH_COARSE);
    localparam int PH_WT_W      = PH_FINE_W + 1;

    typedef struct packed {
        logic [PH_SEL_W-1:0]  coarse;
        logic [PH_FINE_W-1:0] fine;
    } ph_code_t;

    typedef struct packed {
        logic [PH_SEL_W-1:0] sel_a;
        logic [PH_SEL_W-1:0] sel_b;
        logic [PH_WT_W-1:0]  wt_a;
        logic [PH_WT_W-1:0]  wt_b;
    } interp_ctl_t;

    function automatic logic [PH_SEL_W-1:0] next_coarse(input logic [PH_SEL_W-1:0] c);
        return (c == PH_SEL_W'(PH_COARSE - 1)) ? '0 : c + 1'b1;
    endfunction
endpackage

// File: rtl/bb_phase_accum.sv
`timescale 1ns/1ps
module bb_phase_accum
    import bb_phase_pkg::*;
#(
    parameter int FRAC_BITS = 2,
    parameter int STEP      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_vld,
    input  logic                 pd_early,
    output logic [PH_CODE_W-1:0] code
);
    localparam int ACC_W = PH_CODE_W + FRAC_BITS;
    localparam int MOD   = PH_CODE_SPAN << FRAC_BITS;
    localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(MOD);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] up_val;
    logic [ACC_W-1:0] dn_val;

    always_comb begin
        up_val = acc + STEP_V;
        if (up_val >= MOD_V) up_val = up_val - MOD_V;
        if (acc >= STEP_V) dn_val = acc - STEP_V;
        else               dn_val = acc + (MOD_V - STEP_V);
    end

    always_ff @(posedge clk) begin
        if (rst)          acc <= '0;
        else if (upd_vld) acc <= pd_early ? up_val : dn_val;
    end

    generate
        if (FRAC_BITS == 0) begin : g_nofrac
            assign code = acc;
        end else begin : g_frac
            assign code = acc[ACC_W-1:FRAC_BITS];
        end
    endgenerate

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_vld |=> $stable(acc));

    // R3
    up_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && pd_early && (acc < MOD_V - STEP_V)) |=> (acc > $past(acc)));

    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && !pd_early && (acc < STEP_V)) |=> (acc >= MOD_V - STEP_V));
endmodule

// File: rtl/bb_code_split.sv
`timescale 1ns/1ps
module bb_code_split
    import bb_phase_pkg::*;
(
    input  logic [PH_CODE_W-1:0] code,
    output interp_ctl_t          ctl
);
    ph_code_t pc;

    always_comb begin
        pc        = ph_code_t'(code);
        ctl.sel_a = pc.coarse;
        ctl.sel_b = next_coarse(pc.coarse);
        ctl.wt_b  = {1'b0, pc.fine};
        ctl.wt_a  = PH_WT_W'(PH_FINE) - {1'b0, pc.fine};
    end
endmodule

// File: rtl/bb_lock_detect.sv
`timescale 1ns/1ps
module bb_lock_detect #(
    parameter int WIN_LEN   = 8,
    parameter int LOCK_WINS = 16,
    parameter int RUN_LEN   = 8,
    parameter int BAL_TOL   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_vld,
    input  logic pd_early,
    output logic lock
);
    localparam int WP_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int UP_W  = $clog2(WIN_LEN + 1);
    localparam int GC_W  = (LOCK_WINS > 1) ? $clog2(LOCK_WINS) : 1;
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [WP_W-1:0]  win_pos;
    logic [UP_W-1:0]  ups, ups_n;
    logic [GC_W-1:0]  good_cnt;
    logic [RUN_W-1:0] run_cnt, run_n;
    logic             last_dir;
    logic             win_close, win_bal, run_hit;
    int               diff;

    always_comb begin
        ups_n     = ups + UP_W'(pd_early);
        win_close = (win_pos == WP_W'(WIN_LEN - 1));
        diff      = 2 * int'(ups_n) - WIN_LEN;
        win_bal   = (diff <= BAL_TOL) && (diff >= -BAL_TOL);
        if (pd_early == last_dir && run_cnt != '0)
            run_n = (run_cnt == RUN_W'(RUN_LEN)) ? run_cnt : run_cnt + 1'b1;
        else
            run_n = RUN_W'(1);
        run_hit = (run_n == RUN_W'(RUN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_pos  <= '0;
            ups      <= '0;
            good_cnt <= '0;
            run_cnt  <= '0;
            last_dir <= 1'b0;
            lock     <= 1'b0;
        end else if (upd_vld) begin
            run_cnt  <= run_n;
            last_dir <= pd_early;
            if (win_close) begin
                win_pos <= '0;
                ups     <= '0;
                if (win_bal) begin
                    if (good_cnt == GC_W'(LOCK_WINS - 1)) lock <= 1'b1;
                    else                                  good_cnt <= good_cnt + 1'b1;
                end else begin
                    good_cnt <= '0;
                end
            end else begin
                win_pos <= win_pos + 1'b1;
                ups     <= ups_n;
            end
            if (run_hit) begin
                lock     <= 1'b0;
                good_cnt <= '0;
            end
        end
    end

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(upd_vld));

    // R10
    run_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == RUN_W'(RUN_LEN)) |-> !lock);

    // R2
    lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_vld |=> $stable(lock));
endmodule

// File: rtl/bb_phase_ctrl.sv
`timescale 1ns/1ps
module bb_phase_ctrl
    import bb_phase_pkg::*;
#(
    parameter int FRAC_BITS = 2,
    parameter int STEP      = 2,
    parameter int WIN_LEN   = 8,
    parameter int LOCK_WINS = 16,
    parameter int RUN_LEN   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_vld,
    input  logic       pd_early,
    output logic [3:0] coarse_sel,
    output logic [3:0] next_sel,
    output logic [3:0] wt_this,
    output logic [3:0] wt_next,
    output logic       lock
);
    logic [PH_CODE_W-1:0] code;
    interp_ctl_t          ctl;

    bb_phase_accum #(.FRAC_BITS(FRAC_BITS), .STEP(STEP)) u_accum (
        .clk(clk), .rst(rst), .upd_vld(upd_vld), .pd_early(pd_early), .code(code)
    );

    bb_code_split u_split (.code(code), .ctl(ctl));

    bb_lock_detect #(
        .WIN_LEN(WIN_LEN), .LOCK_WINS(LOCK_WINS), .RUN_LEN(RUN_LEN), .BAL_TOL(2)
    ) u_lock (
        .clk(clk), .rst(rst), .upd_vld(upd_vld), .pd_early(pd_early), .lock(lock)
    );

    assign coarse_sel = ctl.sel_a;
    assign next_sel   = ctl.sel_b;
    assign wt_this    = ctl.wt_a;
    assign wt_next    = ctl.wt_b;

    // R4
    coarse_range_chk: assert property (@(posedge clk) disable iff (rst)
        coarse_sel < 4'(PH_COARSE));

    // R4
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && pd_early && wt_next != 4'd0) |=> (coarse_sel == $past(coarse_sel)) || (wt_next == 4'd0));
endmodule

// File: tb/bb_phase_ctrl_tb.sv
`timescale 1ns/1ps
module bb_phase_ctrl_tb_top;
    localparam int ACC_MOD = 96 * 4;
    localparam int STEPV   = 2;
    localparam int NROWS   = 7;
    // row: {vld, early, reps[7:0], exp_code[6:0]}
    localparam logic [16:0] VEC [NROWS] = '{
        {1'b1, 1'b0, 8'd1,  7'd95},
        {1'b1, 1'b1, 8'd1,  7'd0},
        {1'b1, 1'b1, 8'd16, 7'd8},
        {1'b0, 1'b1, 8'd5,  7'd8},
        {1'b1, 1'b1, 8'd3,  7'd9},
        {1'b1, 1'b0, 8'd10, 7'd4},
        {1'b1, 1'b0, 8'd10, 7'd95}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic upd_vld = 1'b0;
    logic pd_early = 1'b0;
    logic [3:0] coarse_sel, next_sel, wt_this, wt_next;
    logic lock;

    int n_chk = 0;
    int n_bad = 0;
    int model_acc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bb_phase_ctrl dut_i (
        .clk(clk), .rst(rst), .upd_vld(upd_vld), .pd_early(pd_early),
        .coarse_sel(coarse_sel), .next_sel(next_sel),
        .wt_this(wt_this), .wt_next(wt_next), .lock(lock)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_code(input string tag);
        int c;
        c = model_acc / 4;
        chk({tag, " R4 coarse"}, int'(coarse_sel), c / 8);
        chk({tag, " R4 weight"}, int'(wt_next), c % 8);
        chk({tag, " R6 wt_this"}, int'(wt_this), 8 - (c % 8));
        chk({tag, " R7 next_sel"}, int'(next_sel), ((c / 8) + 1) % 12);
    endtask

    task automatic do_upd(input logic v, input logic e);
        @(negedge clk);
        upd_vld  = v;
        pd_early = e;
        @(posedge clk);
        #1;
        upd_vld = 1'b0;
        if (v) model_acc = e ? (model_acc + STEPV) % ACC_MOD
                             : (model_acc + ACC_MOD - STEPV) % ACC_MOD;
        chk_code("R3 step");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        upd_vld = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        model_acc = 0;
        chk_code("R1 reset");
        chk("R1 lock", int'(lock), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // vector walk: R3, R5 wrap down/up, R4 carry, R2 idle
        for (int r = 0; r < NROWS; r++) begin
            for (int k = 0; k < int'(VEC[r][14:7]); k++)
                do_upd(VEC[r][16], VEC[r][15]);
            chk($sformatf("row %0d R5 R2 code", r), int'(coarse_sel) * 8 + int'(wt_next),
                int'(VEC[r][6:0]));
        end

        // R2: idle cycles with vote toggling must not move lock or code
        do_upd(1'b0, 1'b0);
        chk("R2 idle lock", int'(lock), 0);

        // R8 / R10: alternating votes give perfectly balanced windows
        do_reset();
        for (int i = 0; i < 127; i++) do_upd(1'b1, (i % 2) == 0);
        chk("R8 before 16th window", int'(lock), 0);
        do_upd(1'b1, 1'b0);
        chk("R8 after 16th window", int'(lock), 1);
        for (int i = 0; i < 5; i++) do_upd(1'b0, 1'b1);
        chk("R2 lock held on idle", int'(lock), 1);
        for (int i = 0; i < 7; i++) do_upd(1'b1, 1'b1);
        chk("R10 run of 7 keeps lock", int'(lock), 1);
        do_upd(1'b1, 1'b1);
        chk("R10 run of 8 clears lock", int'(lock), 0);

        // R1 reset mid-run, then R9 restart after an unbalanced window
        do_reset();
        for (int i = 0; i < 120; i++) do_upd(1'b1, (i % 2) == 0);
        for (int i = 0; i < 8; i++) do_upd(1'b1, (i % 4) != 3);
        chk("R9 unbalanced 6/2 window", int'(lock), 0);
        for (int w = 0; w < 15; w++)
            for (int i = 0; i < 8; i++) do_upd(1'b1, (i == 0) || (i == 1) || (i == 3) || (i == 4) || (i == 6));
        chk("R9 15 windows after restart", int'(lock), 0);
        for (int i = 0; i < 8; i++) do_upd(1'b1, (i == 0) || (i == 1) || (i == 3) || (i == 4) || (i == 6));
        chk("R8 5/3 windows reach lock", int'(lock), 1);

        do_reset();
        finish_run();
    end
endmodule